// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It runs on the system clock and advances on a one-cycle enable pulse, `os_tick`, which the surrounding logic supplies at sixteen times the bit rate. A new character begins only when the idle receiver sees the line go from high to low. From that tick on, every bit lasts sixteen ticks. The receiver takes three consecutive samples around the middle of each bit and decides the bit's value by majority.

Each character can carry five to eight data bits, sent least significant bit first. An even or odd parity bit may follow, and then one or two stop bits. If a start bit reads high at its middle, the receiver treats it as noise and goes back to waiting. Each finished character is presented with a one-cycle strobe and three flags: parity error, framing error and break. After a character whose stop bit is low, the receiver waits for the line to return high before it looks for another start.

Top module: `async_rx`

## Requirements
- R1: A character starts only when the tick sample of the line is 0 and the previous tick sample was 1 while the receiver is idle. A line held low from reset, or held low after a character, starts nothing.
- R2: The tick on which the start is detected is tick 0. Bit n covers ticks 16n to 16n+15. The value of each bit is the majority of the line samples at ticks 16n+7, 16n+8 and 16n+9, so a single wrong sample among the three does not change the bit.
- R3: If the start bit's majority value is 1, the receiver returns to idle and produces no character. A following valid character is received normally.
- R4: `len_sel` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. `rx_data` is right-aligned, and any bits above the selected length read 0.
- R5: `par_mode` selects parity: 00 or 11 gives no parity bit, 01 gives even parity, 10 gives odd parity. `err_parity` is 1 when the data bits and the parity bit together have an odd count of ones in even mode, or an even count in odd mode.
- R6: `stop2` = 0 checks one stop bit, and `stop2` = 1 checks two. `err_frame` is 1 when a checked stop bit reads 0. If the first stop bit reads 0, the character ends there and the second stop bit is not examined.
- R7: `err_break` is 1 when all data bits, the parity bit (if one is used) and the first stop bit read 0. A break also sets `err_frame`, and `rx_data` is then 0.
- R8: After a character whose stop bit read 0, no new character starts until the line has been sampled high again.
- R9: `rx_valid` is high for exactly one clock cycle. That cycle directly follows the tick that takes the third sample of the last checked stop bit. `rx_data` and the flags keep their values until the next `rx_valid`.
- R10: `len_sel`, `par_mode` and `stop2` are captured when the start is detected. Changing them during a character has no effect on that character.
- R11: After reset, `rx_valid`, `rx_data` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line; idles high |
| len_sel | input | 2 | Data length select (5 to 8 bits) |
| par_mode | input | 2 | Parity select: none, even or odd |
| stop2 | input | 1 | 1 = check two stop bits |
| rx_data | output | DATA_W | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| err_parity | output | 1 | Parity error for the presented character |
| err_frame | output | 1 | Stop bit read as 0 |
| err_break | output | 1 | Whole character, including the first stop bit, read as 0 |

## Verification
The bench builds the receiver with its default parameters: sixteen ticks per bit, an 8-bit data path and a two-stage input synchronizer. One tick is issued every four clocks. Because the synchronizer delay is shorter than the gap between ticks, the bench knows which tick sees each line value. It can therefore place single and double sample faults exactly on ticks 7, 8 and 9 of a chosen bit, and it can check the strobe on the exact tick of the stop bit. The 8-bit path makes all four data lengths, both parity senses, and both break and non-break frames with a low stop bit reachable in one run.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT
  } rx_state_e;

  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  function automatic logic parity_used(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int OSR = 16,
  localparam int CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          line,
  output logic          done,
  output logic          bit_o
);

  localparam int MID = OSR / 2;

  logic s_early;
  logic s_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick) begin
      if (cnt == CW'(MID - 1)) s_early <= line;
      if (cnt == CW'(MID))     s_mid   <= line;
    end
  end

  assign done  = tick && (cnt == CW'(MID + 1));
  assign bit_o = (s_early & s_mid) | (s_early & line) | (s_mid & line);

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import async_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(OSR),
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        par_mode,
  input  logic              stop2,
  input  logic              vote_done,
  input  logic              vote_bit,
  output logic [CW-1:0]     cnt,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);

  localparam int MINB = DATA_W - 3;

  rx_state_e         state;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     last_idx;
  logic [DATA_W-1:0] shreg;
  logic [1:0]        par_l;
  logic              stop2_l;
  logic              par_acc;
  logic              any_one;
  logic              stop_idx;
  logic              last_smp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      last_idx <= '0;
      shreg    <= '0;
      par_l    <= '0;
      stop2_l  <= 1'b0;
      par_acc  <= 1'b0;
      any_one  <= 1'b0;
      stop_idx <= 1'b0;
      last_smp <= 1'b0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
      brk_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) last_smp <= line;
      case (state)
        ST_IDLE: begin
          if (tick && !line && last_smp) begin
            state    <= ST_START;
            cnt      <= CW'(1);
            idx      <= '0;
            last_idx <= IW'(MINB - 1) + IW'(len_sel);
            par_l    <= par_mode;
            stop2_l  <= stop2;
            shreg    <= '0;
            par_acc  <= 1'b0;
            any_one  <= 1'b0;
            stop_idx <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (tick && line) state <= ST_IDLE;
        end
        default: begin
          if (tick) cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
          if (vote_done) begin
            case (state)
              ST_START: state <= vote_bit ? ST_IDLE : ST_DATA;
              ST_DATA: begin
                shreg[idx] <= vote_bit;
                par_acc    <= par_acc ^ vote_bit;
                any_one    <= any_one | vote_bit;
                if (idx == last_idx)
                  state <= parity_used(par_l) ? ST_PAR : ST_STOP;
                else
                  idx <= idx + 1'b1;
              end
              ST_PAR: begin
                par_acc <= par_acc ^ vote_bit;
                any_one <= any_one | vote_bit;
                state   <= ST_STOP;
              end
              ST_STOP: begin
                if (!vote_bit) begin
                  valid_o <= 1'b1;
                  data_o  <= shreg;
                  perr_o  <= parity_used(par_l) && (par_acc ^ (par_l == PM_ODD));
                  ferr_o  <= 1'b1;
                  brk_o   <= !any_one && !stop_idx;
                  state   <= ST_WAIT;
                end else if (stop2_l && !stop_idx) begin
                  stop_idx <= 1'b1;
                end else begin
                  valid_o <= 1'b1;
                  data_o  <= shreg;
                  perr_o  <= parity_used(par_l) && (par_acc ^ (par_l == PM_ODD));
                  ferr_o  <= 1'b0;
                  brk_o   <= 1'b0;
                  state   <= ST_IDLE;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        par_mode,
  input  logic              stop2,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break
);

  localparam int CW = $clog2(OSR);

  logic          line;
  logic [CW-1:0] cnt;
  logic          vote_done;
  logic          vote_bit;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (line)
  );

  rx_vote #(.OSR(OSR)) u_vote (
    .clk   (clk),
    .rst   (rst),
    .tick  (os_tick),
    .cnt   (cnt),
    .line  (line),
    .done  (vote_done),
    .bit_o (vote_bit)
  );

  rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .line      (line),
    .len_sel   (len_sel),
    .par_mode  (par_mode),
    .stop2     (stop2),
    .vote_done (vote_done),
    .vote_bit  (vote_bit),
    .cnt       (cnt),
    .data_o    (rx_data),
    .valid_o   (rx_valid),
    .perr_o    (err_parity),
    .ferr_o    (err_frame),
    .brk_o     (err_break)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              os_tick,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_break
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(os_tick)); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable({rx_data, err_parity, err_frame, err_break})); // R9

  AST_BREAK_IS_FRAME_ERR: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && err_break) |-> (err_frame && rx_data == '0)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rx_valid && !err_frame && !err_break && !err_parity)); // R11

endmodule

bind async_rx async_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .os_tick    (os_tick),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_break  (err_break)
);

// File: tb/sim_async_rx.sv
`timescale 1ns/1ps
module sim_async_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic [1:0] par_mode = 2'b00;
  logic       stop2 = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       err_parity, err_frame, err_break;

  int n_checks = 0;
  int n_fail   = 0;
  int vcnt     = 0;
  logic [7:0] cap_data;
  logic cap_p, cap_f, cap_b;
  logic done = 1'b0;

  always #5 clk = ~clk;

  async_rx u0 (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .len_sel(len_sel), .par_mode(par_mode), .stop2(stop2),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt     <= vcnt + 1;
      cap_data <= rx_data;
      cap_p    <= err_parity;
      cap_f    <= err_frame;
      cap_b    <= err_break;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fields: len[15:14] par[13:12] stop2[11] data[10:3] bad_par[2] bad_stop1[1] bad_stop2[0]
  localparam logic [15:0] VEC [12] = '{
    {2'd3, 2'd0, 1'b0, 8'hA5, 3'b000},
    {2'd3, 2'd1, 1'b0, 8'h3C, 3'b000},
    {2'd3, 2'd2, 1'b0, 8'h3C, 3'b000},
    {2'd3, 2'd1, 1'b0, 8'h81, 3'b100},
    {2'd2, 2'd2, 1'b1, 8'h7F, 3'b000},
    {2'd1, 2'd0, 1'b1, 8'h2A, 3'b001},
    {2'd0, 2'd1, 1'b0, 8'h1F, 3'b000},
    {2'd0, 2'd3, 1'b0, 8'h15, 3'b010},
    {2'd3, 2'd1, 1'b0, 8'h00, 3'b010},
    {2'd3, 2'd2, 1'b0, 8'h00, 3'b010},
    {2'd2, 2'd0, 1'b0, 8'h00, 3'b010},
    {2'd3, 2'd2, 1'b0, 8'h00, 3'b110}
  };

  task automatic slot(input logic v);
    @(negedge clk);
    rx_in = v;
    repeat (2) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input logic [2:0] g);
    for (int k = 0; k < 16; k++) begin
      if (k >= 7 && k <= 9) slot(v ^ g[k-7]);
      else slot(v);
    end
  endtask

  function automatic logic [7:0] len_mask(input int nb);
    return 8'hFF >> (8 - nb);
  endfunction

  task automatic send_frame(input logic [1:0] ls, input logic [1:0] pm, input logic s2,
                            input logic [7:0] d, input logic bp, input logic bs1,
                            input logic bs2, input logic [23:0] gl, input logic scr);
    int nb;
    logic [7:0] dm;
    logic pb;
    nb = 5 + int'(ls);
    dm = d & len_mask(nb);
    pb = ((pm == 2'b10) ? ~^dm : ^dm) ^ bp;
    len_sel = ls; par_mode = pm; stop2 = s2;
    send_bit(1'b0, 3'b000);
    if (scr) begin
      len_sel = ~ls; par_mode = (pm == 2'b00) ? 2'b01 : 2'b00; stop2 = ~s2;
    end
    for (int i = 0; i < nb; i++) send_bit(dm[i], gl[3*i +: 3]);
    if (pm == 2'b01 || pm == 2'b10) send_bit(pb, 3'b000);
    send_bit(~bs1, 3'b000);
    if (s2) send_bit(bs1 ? 1'b1 : ~bs2, 3'b000);
    for (int k = 0; k < 4; k++) slot(1'b1);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid", rx_valid, 0);
    chk("R11 data", rx_data, 0);
    chk("R11 flags", {err_parity, err_frame, err_break}, 0);
    for (int k = 0; k < 4; k++) slot(1'b1);

    // table walk: R4 R5 R6 R7 R9
    foreach (VEC[i]) begin
      logic [1:0] ls, pm; logic s2, bp, bs1, bs2; logic [7:0] d, dm; logic pb; int nb;
      logic ep, ef, eb;
      {ls, pm, s2, d, bp, bs1, bs2} = VEC[i];
      nb = 5 + int'(ls);
      dm = d & len_mask(nb);
      pb = ((pm == 2'b10) ? ~^dm : ^dm) ^ bp;
      ep = (pm == 2'b01 || pm == 2'b10) && bp;
      ef = bs1 | (s2 & bs2);
      eb = (dm == 0) && ((pm == 2'b00 || pm == 2'b11) || !pb) && bs1;
      v0 = vcnt;
      send_frame(ls, pm, s2, d, bp, bs1, bs2, 24'd0, 1'b0);
      chk("R9 one strobe per character", vcnt - v0, 1);
      chk("R4 data", cap_data, dm);
      chk("R5 parity flag", cap_p, ep);
      chk("R6 framing flag", cap_f, ef);
      chk("R7 break flag", cap_b, eb);
    end

    // R2 majority: single faults ignored, double faults win
    v0 = vcnt;
    send_frame(2'd3, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0,
               {3'b100, 3'b000, 3'b101, 3'b000, 3'b000, 3'b011, 3'b010, 3'b010}, 1'b0);
    chk("R2 vote count", vcnt - v0, 1);
    chk("R2 majority data", cap_data, 8'h24);

    // R3 false start: short low pulse, then low with high centre
    v0 = vcnt;
    for (int k = 0; k < 6; k++) slot(1'b0);
    for (int k = 0; k < 30; k++) slot(1'b1);
    for (int k = 0; k < 16; k++) slot((k == 7 || k == 8) ? 1'b1 : 1'b0);
    for (int k = 0; k < 30; k++) slot(1'b1);
    chk("R3 false start ignored", vcnt - v0, 0);
    send_frame(2'd3, 2'd1, 1'b0, 8'h5B, 1'b0, 1'b0, 1'b0, 24'd0, 1'b0);
    chk("R3 next character", cap_data, 8'h5B);

    // R10 configuration captured at start
    send_frame(2'd3, 2'd1, 1'b0, 8'h96, 1'b0, 1'b0, 1'b0, 24'd0, 1'b1);
    chk("R10 data", cap_data, 8'h96);
    chk("R10 flags", {cap_p, cap_f, cap_b}, 0);

    // R8 break then long low: no new character until high
    len_sel = 2'd3; par_mode = 2'd0; stop2 = 1'b0;
    v0 = vcnt;
    for (int k = 0; k < 160 + 48; k++) slot(1'b0);
    chk("R8 single break character", vcnt - v0, 1);
    chk("R7 break seen", cap_b, 1);
    for (int k = 0; k < 4; k++) slot(1'b1);
    send_frame(2'd3, 2'd0, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0, 24'd0, 1'b0);
    chk("R8 rearmed", cap_data, 8'hC3);

    // R9 exact strobe timing: 5 bits, no parity, one stop
    len_sel = 2'd0; par_mode = 2'd0; stop2 = 1'b0;
    for (int k = 0; k < 16; k++) slot(1'b0);
    for (int b = 0; b < 5; b++) send_bit(b != 2, 3'b000);
    for (int k = 0; k < 16; k++) begin
      slot(1'b1);
      if (k == 8) chk("R9 no strobe before third sample", rx_valid, 0);
      if (k == 9) begin
        chk("R9 strobe after third sample", rx_valid, 1);
        chk("R9 data", rx_data, 8'h1B);
      end
      if (k == 10) chk("R9 strobe one cycle", rx_valid, 0);
    end

    // R1 line low from reset starts nothing
    rx_in = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    v0 = vcnt;
    for (int k = 0; k < 200; k++) slot(1'b0);
    chk("R1 no start without edge", vcnt - v0, 0);
    for (int k = 0; k < 4; k++) slot(1'b1);
    send_frame(2'd3, 2'd2, 1'b0, 8'h3E, 1'b0, 1'b0, 1'b0, 24'd0, 1'b0);
    chk("R1 start after edge", cap_data, 8'h3E);
    chk("R1 parity clean", cap_p, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule